// File: doc/BRIEF.md
# Bus Response Timeout Monitor

This block watches every bus cycle for a data/size acknowledge. When a cycle begins, it loads a response limit. If the acknowledge does not come within that limit, the block raises a one-clock internal bus-error pulse. The limit is picked by a two-bit select from four values. Internal cycles are always timed. Timing of external cycles can be switched off with an enable.

Interrupt-acknowledge cycles get one more check. If no arbitration response is seen in a short fixed window after the cycle begins, the block reports a spurious-interrupt bus error. The error is for internal use only. Driving a bus-error pin is left to other logic.

The select, the external enable and the cycle attributes are sampled on the clock where the cycle starts. A new cycle start drops any cycle still open. Each cycle ends with an acknowledge, with at most one bus error, or with neither.

Top module: `bto_monitor`

## Requirements
- R1: While reset is active and in the clock after it, `berr` is low.
- R2: A timed cycle that gets no acknowledge drives `berr` high for exactly one clock. The pulse starts L clock edges after the edge that sampled `cyc_start`. L is 64, 32, 16 or 8 for `tmo_sel` codes 00, 01, 10 and 11.
- R3: An acknowledge sampled on any of the L edges after the start edge ends the cycle without a bus error. This includes the L-th edge, where the acknowledge wins over expiry.
- R4: An external cycle (`cyc_ext`=1) is timed when `ext_mon_en`=1. When `ext_mon_en`=0 it never produces a timeout bus error.
- R5: An internal cycle (`cyc_ext`=0) is timed with the selected limit whatever the value of `ext_mon_en`.
- R6: `tmo_sel` and `ext_mon_en` are sampled only at the start edge. Changing them during a cycle does not move or suppress its bus error.
- R7: An interrupt-acknowledge cycle (`cyc_iack`=1) must see `arb_resp` or `ack` on one of the 4 edges after the start edge. If it sees neither, `berr` pulses for one clock starting 4 edges after the start edge. This check applies to internal and external cycles and does not depend on `ext_mon_en`.
- R8: An interrupt-acknowledge cycle whose `arb_resp` is sampled inside the 4-edge window, including the 4th edge, gets no spurious error and then follows normal acknowledge timing.
- R9: A `cyc_start` during an open cycle drops that cycle without an error and restarts timing from the new start edge.
- R10: A cycle produces at most one `berr` pulse. After it, `berr` stays low until a new cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe: a bus cycle begins |
| cyc_ext | input | 1 | 1 = external cycle, 0 = internal cycle (sampled at start) |
| cyc_iack | input | 1 | 1 = interrupt-acknowledge cycle (sampled at start) |
| ack | input | 1 | Data/size acknowledge for the open cycle |
| arb_resp | input | 1 | Interrupt arbitration response seen |
| tmo_sel | input | 2 | Limit code: 00=64, 01=32, 10=16, 11=8 clocks |
| ext_mon_en | input | 1 | 1 = time external cycles too |
| berr | output | 1 | One-clock internal bus-error pulse |

## Verification
Two events can fall on the same edge: an acknowledge arriving on the very edge where the limit expires, and a new cycle start arriving while an old cycle is about to expire. The bench puts `ack` on the L-th edge and on the 4th edge of an unarbitrated interrupt acknowledge. It also restarts a cycle shortly before its limit. A behavioural reference model judges every clock, and its result must show no pulse for the finished or dropped cycle and exactly one pulse, correctly timed, for the restarted cycle.

// File: rtl/bto_pkg.sv
// Package for the bus response timeout monitor.
// Holds the select width and the limit-table size that the modules share.
package bto_pkg;
    localparam int SEL_W = 2;
    localparam int NSEL  = 1 << SEL_W;
endpackage

// File: rtl/bto_limit_sel.sv
// Limit selector: turns the select code into a response limit.
// Code i gives LIM_MAX >> i.
// Assumes LIM_MAX >> (NSEL-1) is at least 1.
module bto_limit_sel
    import bto_pkg::*;
#(
    parameter int LIM_MAX = 64,
    parameter int CW      = $clog2(LIM_MAX + 1)
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CW-1:0]    limit
);
    logic [CW-1:0] table_q [NSEL];

    // Build one table entry per code.
    for (genvar i = 0; i < NSEL; i++) begin : g_tbl
        assign table_q[i] = CW'(LIM_MAX >> i);
    end

    // Pick the entry for the current code.
    always_comb limit = table_q[sel];
endmodule

// File: rtl/bto_down_timer.sv
// One-shot down timer.
// Loads a span on start. It runs only if armed at that start. It stops on
// stop. If it is not stopped before its span runs out, it expires once.
// 'fire' goes high in the clock whose edge will end the span, so the caller
// can cancel other work on that same edge. 'expired' is the registered
// one-clock pulse that follows.
// Assumes span >= 1.
module bto_down_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         arm,
    input  logic [W-1:0] span,
    input  logic         stop,
    output logic         fire,
    output logic         expired
);
    logic         run_q;
    logic [W-1:0] rem_q;

    // The span runs out on this edge unless a start or a stop arrives too.
    always_comb fire = run_q && !start && !stop && (rem_q == W'(1));

    // Run state and remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            rem_q <= '0;
        end else if (start) begin
            run_q <= arm;
            rem_q <= span;
        end else if (run_q) begin
            if (stop || fire) run_q <= 1'b0;
            else              rem_q <= rem_q - W'(1);
        end
    end

    // Registered expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) expired <= 1'b0;
        else        expired <= fire;
    end
endmodule

// File: rtl/bto_monitor.sv
// Bus response timeout monitor (top).
// It runs two timers from each cycle start:
//   - an acknowledge timer, armed for internal cycles and for external
//     cycles when external monitoring is on;
//   - an arbitration timer, armed for interrupt-acknowledge cycles.
// The spurious-interrupt expiry cancels the acknowledge timer on the same
// edge, so a cycle gives at most one error.
// Assumes ARB_WIN < (LIM_MAX >> 3) and cyc_start is a one-clock strobe.
module bto_monitor
    import bto_pkg::*;
#(
    parameter int LIM_MAX = 64,
    parameter int ARB_WIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             cyc_ext,
    input  logic             cyc_iack,
    input  logic             ack,
    input  logic             arb_resp,
    input  logic [SEL_W-1:0] tmo_sel,
    input  logic             ext_mon_en,
    output logic             berr
);
    localparam int CW = $clog2(LIM_MAX + 1);

    logic [CW-1:0] limit;
    logic          timed;
    logic          arb_fire, arb_exp;
    logic          ack_fire, ack_exp;

    bto_limit_sel #(.LIM_MAX(LIM_MAX), .CW(CW)) u_lim (
        .sel   (tmo_sel),
        .limit (limit)
    );

    // A cycle is timed if it is internal, or if external monitoring is on.
    always_comb timed = !cyc_ext || ext_mon_en;

    bto_down_timer #(.W(CW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cyc_start),
        .arm     (cyc_iack),
        .span    (CW'(ARB_WIN)),
        .stop    (ack || arb_resp),
        .fire    (arb_fire),
        .expired (arb_exp)
    );

    bto_down_timer #(.W(CW)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cyc_start),
        .arm     (timed),
        .span    (limit),
        .stop    (ack || arb_fire),
        .fire    (ack_fire),
        .expired (ack_exp)
    );

    // Merge the two registered expiry pulses into the bus-error output.
    always_comb berr = ack_exp || arb_exp;
endmodule

// File: rtl/bto_monitor_chk.sv
// Checker for bto_monitor.
// It tracks the age of the current cycle and the attributes latched at its
// start, then checks when a bus error may appear.
module bto_monitor_chk
    import bto_pkg::*;
#(
    parameter int LIM_MAX = 64,
    parameter int ARB_WIN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_start,
    input logic             cyc_ext,
    input logic             cyc_iack,
    input logic             ack,
    input logic [SEL_W-1:0] tmo_sel,
    input logic             ext_mon_en,
    input logic             berr
);
    localparam int AW = $clog2(LIM_MAX + 2) + 1;
    localparam logic [AW-1:0] AMAX = '1;

    logic [AW-1:0] age_q;
    logic [AW-1:0] lim_q;
    logic          timed_q;
    logic          iack_q;

    // Age of the current cycle and the attributes latched at its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q   <= '0;
            lim_q   <= '0;
            timed_q <= 1'b0;
            iack_q  <= 1'b0;
        end else if (cyc_start) begin
            age_q   <= '0;
            lim_q   <= AW'(LIM_MAX >> tmo_sel);
            timed_q <= !cyc_ext || ext_mon_en;
            iack_q  <= cyc_iack;
        end else if (age_q != AMAX) begin
            age_q   <= age_q + AW'(1);
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !berr); // R1
    AST_BERR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> ((timed_q && age_q == lim_q) || (iack_q && age_q == AW'(ARB_WIN)))); // R2
    AST_ACK_NO_BERR: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !berr); // R3
    AST_UNTIMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> (timed_q || iack_q)); // R4
    AST_START_NO_BERR: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !berr); // R9
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        berr |=> !berr); // R10
endmodule

bind bto_monitor bto_monitor_chk #(.LIM_MAX(LIM_MAX), .ARB_WIN(ARB_WIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .cyc_ext    (cyc_ext),
    .cyc_iack   (cyc_iack),
    .ack        (ack),
    .tmo_sel    (tmo_sel),
    .ext_mon_en (ext_mon_en),
    .berr       (berr)
);

// File: tb/bto_monitor_test.sv
// Bench for bto_monitor.
// A behavioural reference model predicts berr and is compared on every
// clock. Each scenario also checks how many pulses it saw.
module bto_monitor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0, cyc_ext = 1'b0, cyc_iack = 1'b0;
    logic       ack = 1'b0, arb_resp = 1'b0, ext_mon_en = 1'b0;
    logic [1:0] tmo_sel = 2'b00;
    logic       berr;

    int    checks = 0, errors = 0, pulses = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // Reference model state.
    bit exp_berr = 1'b0, live = 1'b0, m_timed = 1'b0, m_iack = 1'b0, m_arbok = 1'b0;
    int age = 0, lim = 0;

    bto_monitor uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_ext(cyc_ext),
        .cyc_iack(cyc_iack), .ack(ack), .arb_resp(arb_resp), .tmo_sel(tmo_sel),
        .ext_mon_en(ext_mon_en), .berr(berr)
    );

    always #10 clk = ~clk;

    // Reference model: advances one step per edge.
    always @(posedge clk) begin
        exp_berr = 1'b0;
        if (!rst_n) begin
            live = 1'b0;
        end else if (cyc_start) begin
            live = 1'b1; age = 0; lim = 64 >> tmo_sel;
            m_timed = !cyc_ext || ext_mon_en; m_iack = cyc_iack; m_arbok = 1'b0;
        end else if (live) begin
            age++;
            if (ack) live = 1'b0;
            else begin
                if (arb_resp) m_arbok = 1'b1;
                if (m_iack && !m_arbok && age == 4) begin exp_berr = 1'b1; live = 1'b0; end
                else if (m_timed && age == lim) begin exp_berr = 1'b1; live = 1'b0; end
            end
        end
    end

    // Compare the output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (berr !== exp_berr) begin
                errors++;
                $display("FAIL %s: berr actual %b expected %b at %0t", tag, berr, exp_berr, $time);
            end
            if (berr === 1'b1) pulses++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_cycle(input bit ext, input bit iack, input logic [1:0] sel);
        cyc_start = 1'b1; cyc_ext = ext; cyc_iack = iack; tmo_sel = sel;
        tick(1);
        cyc_start = 1'b0;
    endtask

    // Drive a one-clock pulse on a signal so it is sampled on edge k after start.
    task automatic ack_at(input int k);
        tick(k - 1); ack = 1'b1; tick(1); ack = 1'b0;
    endtask

    task automatic arb_at(input int k);
        tick(k - 1); arb_resp = 1'b1; tick(1); arb_resp = 1'b0;
    endtask

    task automatic expect_pulses(input int base, input int n, input string t);
        checks++;
        if (pulses - base != n) begin
            errors++;
            $display("FAIL %s: pulse count actual %0d expected %0d", t, pulses - base, n);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung, expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int b;
        // R1: reset state
        tick(3);
        checks++;
        if (berr !== 1'b0) begin errors++; $display("FAIL R1: berr actual %b expected 0", berr); end
        rst_n = 1'b1;
        tick(2);

        // R2: internal cycles, each code, no acknowledge
        for (int s = 0; s < 4; s++) begin
            tag = "R2"; b = pulses;
            begin_cycle(1'b0, 1'b0, 2'(s));
            tick((64 >> s) + 3);
            expect_pulses(b, 1, "R2");
        end

        // R3: acknowledge on the last edge, and early
        tag = "R3"; b = pulses;
        begin_cycle(1'b0, 1'b0, 2'b11); ack_at(8); tick(12);
        begin_cycle(1'b0, 1'b0, 2'b10); ack_at(3); tick(20);
        expect_pulses(b, 0, "R3");

        // R4: external cycle, monitor on then off
        tag = "R4"; b = pulses; ext_mon_en = 1'b1;
        begin_cycle(1'b1, 1'b0, 2'b11); tick(12);
        expect_pulses(b, 1, "R4");
        b = pulses; ext_mon_en = 1'b0;
        begin_cycle(1'b1, 1'b0, 2'b00); tick(80);
        expect_pulses(b, 0, "R4");

        // R5: internal cycle timed while external monitoring is off
        tag = "R5"; b = pulses;
        begin_cycle(1'b0, 1'b0, 2'b01); tick(36);
        expect_pulses(b, 1, "R5");

        // R6: change the select and enable during the cycle
        tag = "R6"; b = pulses; ext_mon_en = 1'b1;
        begin_cycle(1'b1, 1'b0, 2'b11);
        tmo_sel = 2'b00; ext_mon_en = 1'b0;
        tick(70);
        expect_pulses(b, 1, "R6");

        // R7 / R10: unarbitrated interrupt acknowledge, internal and untimed external
        tag = "R7"; b = pulses;
        begin_cycle(1'b0, 1'b1, 2'b00); tick(80);
        expect_pulses(b, 1, "R10");
        b = pulses;
        begin_cycle(1'b1, 1'b1, 2'b00); tick(20);
        expect_pulses(b, 1, "R7");
        b = pulses;
        begin_cycle(1'b0, 1'b1, 2'b11); ack_at(4); tick(12);
        expect_pulses(b, 0, "R7");

        // R8: arbitration inside the window, including its last edge
        tag = "R8"; b = pulses;
        begin_cycle(1'b0, 1'b1, 2'b11); arb_at(2); tick(12);
        expect_pulses(b, 1, "R8");
        b = pulses;
        begin_cycle(1'b1, 1'b1, 2'b11); arb_at(4); tick(70);
        expect_pulses(b, 0, "R8");

        // R9: restart shortly before expiry
        tag = "R9"; b = pulses;
        begin_cycle(1'b0, 1'b0, 2'b11); tick(6);
        begin_cycle(1'b0, 1'b0, 2'b11); tick(12);
        expect_pulses(b, 1, "R9");
        b = pulses;
        begin_cycle(1'b0, 1'b0, 2'b11); tick(7);
        begin_cycle(1'b0, 1'b0, 2'b11); ack_at(5); tick(12);
        expect_pulses(b, 0, "R9");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule